// File: doc/BRIEF.md
# External Bus Strobe Generator

This block sequences the strobes of a multiplexed external memory bus for an 8-bit controller core. It runs on the oscillator clock and divides it into machine cycles of twelve clocks: six states of two clocks each. From that count it drives the following outputs:
- the address-latch pulse, twice per machine cycle;
- the active-low code-fetch strobe, when code runs from outside the chip;
- the active-low data read and write strobes;
- the selectors that tell the pad logic what the shared low byte bus and the high address port carry.

The core requests an external data transfer through a valid/ready handshake. `req_ready` is high for one clock, on the last clock of an ordinary machine cycle, and only when the block is not sleeping. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester holds `req_valid`, `req_write` and `req_wide` steady until that edge, so back-pressure costs it whole machine cycles. An accepted transfer takes the next two machine cycles, called A and B here. During those two cycles one address-latch pulse and two code-fetch pulses are left out. The data strobe lasts six clocks at the start of cycle B.

Software can switch off the address-latch output. The core's control inputs then decide whether that switch applies. The output is kept weakly high while it applies. It is switched off only in certain states, and is held off during a data transfer. Idle and power-down override all strobes. In the text below, count c is the clock position 0 to 11 within a machine cycle.

Top module: `xbus_strobe_gen`

## Requirements
- R1: The address-latch pulse `ale` is high for two clocks at counts 0-1 and 6-7 of each machine cycle, with `ale_strong` = 1. Count 0 is the clock after the one on which `req_ready` was high.
- R2: In cycle B of an accepted transfer, the pulse at counts 0-1 is left out. The pulse at counts 6-7 of B, and both pulses of A, are kept.
- R3: While `ext_exec` = 1, `psen_n` is low at counts 3-5 and 9-11. It stays high at counts 9-11 of cycle A and at counts 3-5 of cycle B.
- R4: While `ext_exec` = 0, `psen_n` stays high.
- R5: When `ale_dis` = 1 and none of `ext_exec`, `code_rd`, `emu_mode`, idle, power-down or a transfer in cycle A or B is active, `ale` is held at 1 with `ale_strong` = 0. Otherwise `ale_dis` has no effect.
- R6: In cycle B, counts 0-5, `rd_n` is low for a read (`req_write` = 0 at acceptance) or `wr_n` is low for a write. The two are never low together.
- R7: `lo_mode` encodes the low byte bus as 0 = float, 1 = address, 2 = data. It is 1 during a pulse window of R1/R2 if `ext_exec` = 1, or in the second half of cycle A. It is 2 at counts 8-11 of A and counts 0-5 of B, and 0 elsewhere. It is never 2 while `ale` is high.
- R8: `hi_addr_sel` is 1 when the high port carries the upper address byte and 0 when it carries its port register. From count 6 of A to count 5 of B it equals the accepted `req_wide`. Elsewhere it equals `ext_exec`.
- R9: `req_ready` is high only at count 11 of a machine cycle that is not cycle A or B, and only with `idle` and `pdown` low. A `req_valid` without `req_ready` starts nothing.
- R10: With `idle` = 1: `ale` = 1, `psen_n` = 1, `rd_n` = `wr_n` = 1, `lo_mode` = 0, `hi_addr_sel` = 0, `req_ready` = 0. `pdown` = 1 gives the same outputs except `ale` = 0 and `psen_n` = 0, and takes priority over `idle`.
- R11: Asynchronous reset (`rst_n` low) places the count at 0 with no transfer. `rd_n` and `wr_n` are high and `req_ready` is low. After release, `req_ready` first rises on the eleventh clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_exec | input | 1 | Code executes from external memory |
| code_rd | input | 1 | Core is reading a constant from code space |
| emu_mode | input | 1 | Emulation mode is active |
| idle | input | 1 | Idle mode |
| pdown | input | 1 | Power-down mode |
| ale_dis | input | 1 | Software switch-off of the address-latch output |
| req_valid | input | 1 | External data transfer requested |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read; held with req_valid |
| req_wide | input | 1 | 1 = 16-bit address, 0 = 8-bit address |
| ale | output | 1 | Address-latch pulse (active high) |
| ale_strong | output | 1 | 1 = ale driven, 0 = ale only weakly held high |
| psen_n | output | 1 | Code-fetch read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| lo_mode | output | 2 | Low byte bus content: 0 float, 1 address, 2 data |
| hi_addr_sel | output | 1 | High port: 1 upper address byte, 0 port register |

## Verification
A wrong cycle count or transfer phase moves the pulse windows. A misplaced latch pulse, a missing skip or a data strobe in the wrong half then appears at the ports within one machine cycle, at most twelve clocks. A transfer flag latched wrongly at acceptance shows as the wrong strobe or the wrong high-port selection in cycle B, up to twenty-four clocks after the handshake. The bench sweeps every combination of the mode inputs and transfer kinds. At each sweep point it compares every output on every clock of the transfer and of the ordinary cycle that follows it.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
  typedef enum logic [1:0] {
    PH_RUN = 2'd0,
    PH_XA  = 2'd1,
    PH_XB  = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    LO_FLOAT = 2'd0,
    LO_ADDR  = 2'd1,
    LO_DATA  = 2'd2
  } lo_mode_e;
endpackage

// File: rtl/xbus_cycle_timer.sv
module xbus_cycle_timer
  import xbus_pkg::*;
#(
  parameter int STATE_CNT     = 6,
  parameter int OSC_PER_STATE = 2,
  localparam int CYC          = STATE_CNT * OSC_PER_STATE,
  localparam int CW           = $clog2(CYC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          idle,
  input  logic          pdown,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          req_wide,
  output logic          req_ready,
  output logic [CW-1:0] cnt,
  output phase_e        phase,
  output logic          wr_q,
  output logic          wide_q
);
  logic last;

  assign last      = (cnt == CW'(CYC - 1));
  assign req_ready = last && (phase == PH_RUN) && !idle && !pdown;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      phase  <= PH_RUN;
      wr_q   <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      cnt <= last ? '0 : cnt + 1'b1;
      if (last) begin
        case (phase)
          PH_RUN: begin
            if (req_valid && req_ready) begin
              phase  <= PH_XA;
              wr_q   <= req_write;
              wide_q <= req_wide;
            end
          end
          PH_XA:   phase <= PH_XB;
          default: phase <= PH_RUN;
        endcase
      end
    end
  end
endmodule

// File: rtl/xbus_window_dec.sv
module xbus_window_dec
  import xbus_pkg::*;
#(
  parameter int STATE_CNT     = 6,
  parameter int OSC_PER_STATE = 2,
  parameter int ALE_W         = 2,
  parameter int STROBE_W      = 6,
  localparam int CYC          = STATE_CNT * OSC_PER_STATE,
  localparam int HALF         = CYC / 2,
  localparam int CW           = $clog2(CYC)
) (
  input  logic [CW-1:0] cnt,
  input  phase_e        phase,
  output logic          ale_win,
  output logic          psen_win,
  output logic          strobe_win,
  output logic          data_win,
  output logic          xfer_win,
  output logic          xaddr_half,
  output logic          busy
);
  always_comb begin
    int  c;
    int  off;
    bit  first_half;
    bit  in_a;
    bit  in_b;
    c          = int'(cnt);
    off        = c % HALF;
    first_half = (c < HALF);
    in_a       = (phase == PH_XA);
    in_b       = (phase == PH_XB);
    // latch pulse: dropped in the first half of cycle B
    ale_win    = (off < ALE_W) && !(in_b && first_half);
    // fetch strobe: dropped in second half of A and first half of B
    psen_win   = (off >= HALF / 2) && !(in_a && !first_half) && !(in_b && first_half);
    strobe_win = in_b && (c < STROBE_W);
    data_win   = (in_a && (c >= HALF + ALE_W)) || strobe_win;
    xfer_win   = (in_a && !first_half) || (in_b && first_half);
    xaddr_half = in_a && !first_half;
    busy       = in_a || in_b;
  end
endmodule

// File: rtl/xbus_pin_ctl.sv
module xbus_pin_ctl
  import xbus_pkg::*;
(
  input  logic     ext_exec,
  input  logic     code_rd,
  input  logic     emu_mode,
  input  logic     idle,
  input  logic     pdown,
  input  logic     ale_dis,
  input  logic     wr_q,
  input  logic     wide_q,
  input  logic     ale_win,
  input  logic     psen_win,
  input  logic     strobe_win,
  input  logic     data_win,
  input  logic     xfer_win,
  input  logic     xaddr_half,
  input  logic     busy,
  output logic     ale,
  output logic     ale_strong,
  output logic     psen_n,
  output logic     rd_n,
  output logic     wr_n,
  output lo_mode_e lo_mode,
  output logic     hi_addr_sel
);
  logic dis_eff;

  assign dis_eff = ale_dis && !(busy || code_rd || emu_mode || idle || pdown || ext_exec);

  always_comb begin
    ale         = 1'b1;
    ale_strong  = 1'b1;
    psen_n      = 1'b1;
    rd_n        = 1'b1;
    wr_n        = 1'b1;
    lo_mode     = LO_FLOAT;
    hi_addr_sel = 1'b0;
    if (pdown) begin
      ale    = 1'b0;
      psen_n = 1'b0;
    end else if (!idle) begin
      ale         = dis_eff ? 1'b1 : ale_win;
      ale_strong  = !dis_eff;
      psen_n      = !(ext_exec && psen_win);
      rd_n        = !(strobe_win && !wr_q);
      wr_n        = !(strobe_win && wr_q);
      hi_addr_sel = xfer_win ? wide_q : ext_exec;
      if (ale_win && (ext_exec || xaddr_half)) lo_mode = LO_ADDR;
      else if (data_win)                       lo_mode = LO_DATA;
    end
  end
endmodule

// File: rtl/xbus_strobe_gen.sv
module xbus_strobe_gen
  import xbus_pkg::*;
#(
  parameter int STATE_CNT     = 6,
  parameter int OSC_PER_STATE = 2,
  parameter int ALE_W         = 2,
  parameter int STROBE_W      = 6,
  localparam int CYC          = STATE_CNT * OSC_PER_STATE,
  localparam int CW           = $clog2(CYC)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ext_exec,
  input  logic       code_rd,
  input  logic       emu_mode,
  input  logic       idle,
  input  logic       pdown,
  input  logic       ale_dis,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_write,
  input  logic       req_wide,
  output logic       ale,
  output logic       ale_strong,
  output logic       psen_n,
  output logic       rd_n,
  output logic       wr_n,
  output logic [1:0] lo_mode,
  output logic       hi_addr_sel
);
  logic [CW-1:0] cnt;
  phase_e        phase;
  logic          wr_q, wide_q;
  logic          ale_win, psen_win, strobe_win, data_win, xfer_win, xaddr_half, busy;
  lo_mode_e      lo_sel;

  xbus_cycle_timer #(.STATE_CNT(STATE_CNT), .OSC_PER_STATE(OSC_PER_STATE)) u_timer (
    .clk(clk), .rst_n(rst_n), .idle(idle), .pdown(pdown),
    .req_valid(req_valid), .req_write(req_write), .req_wide(req_wide),
    .req_ready(req_ready), .cnt(cnt), .phase(phase), .wr_q(wr_q), .wide_q(wide_q)
  );

  xbus_window_dec #(
    .STATE_CNT(STATE_CNT), .OSC_PER_STATE(OSC_PER_STATE),
    .ALE_W(ALE_W), .STROBE_W(STROBE_W)
  ) u_dec (
    .cnt(cnt), .phase(phase), .ale_win(ale_win), .psen_win(psen_win),
    .strobe_win(strobe_win), .data_win(data_win), .xfer_win(xfer_win),
    .xaddr_half(xaddr_half), .busy(busy)
  );

  xbus_pin_ctl u_pins (
    .ext_exec(ext_exec), .code_rd(code_rd), .emu_mode(emu_mode), .idle(idle),
    .pdown(pdown), .ale_dis(ale_dis), .wr_q(wr_q), .wide_q(wide_q),
    .ale_win(ale_win), .psen_win(psen_win), .strobe_win(strobe_win),
    .data_win(data_win), .xfer_win(xfer_win), .xaddr_half(xaddr_half), .busy(busy),
    .ale(ale), .ale_strong(ale_strong), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .lo_mode(lo_sel), .hi_addr_sel(hi_addr_sel)
  );

  assign lo_mode = lo_sel;
endmodule

// File: rtl/xbus_strobe_chk.sv
module xbus_strobe_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ext_exec,
  input logic       idle,
  input logic       pdown,
  input logic       req_ready,
  input logic       ale,
  input logic       ale_strong,
  input logic       psen_n,
  input logic       rd_n,
  input logic       wr_n,
  input logic [1:0] lo_mode
);
  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n));

  // R7
  data_after_ale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lo_mode == 2'd2) |-> !ale);

  // R4
  int_exec_psen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_exec && !pdown) |-> psen_n);

  // R1
  ale_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ale) && ale_strong && !idle && !pdown) |=> (ale || pdown));

  // R6
  rd_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> (!rd_n || idle || pdown));

  // R9
  ready_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R10
  sleep_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle || pdown) |-> !req_ready);
endmodule

bind xbus_strobe_gen xbus_strobe_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ext_exec(ext_exec), .idle(idle), .pdown(pdown),
  .req_ready(req_ready), .ale(ale), .ale_strong(ale_strong), .psen_n(psen_n),
  .rd_n(rd_n), .wr_n(wr_n), .lo_mode(lo_mode)
);

// File: tb/xbus_strobe_gen_tb.sv
module xbus_strobe_gen_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ext_exec = 0, code_rd = 0, emu_mode = 0, idle = 0, pdown = 0, ale_dis = 0;
  logic req_valid = 0, req_write = 0, req_wide = 0;
  logic req_ready, ale, ale_strong, psen_n, rd_n, wr_n, hi_addr_sel;
  logic [1:0] lo_mode;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  xbus_strobe_gen u_dut (
    .clk(clk), .rst_n(rst_n), .ext_exec(ext_exec), .code_rd(code_rd),
    .emu_mode(emu_mode), .idle(idle), .pdown(pdown), .ale_dis(ale_dis),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_wide(req_wide), .ale(ale), .ale_strong(ale_strong), .psen_n(psen_n),
    .rd_n(rd_n), .wr_n(wr_n), .lo_mode(lo_mode), .hi_addr_sel(hi_addr_sel)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // expected outputs at count c; xa/xb mark cycles A and B of a transfer
  task automatic check_pos(input int c, input bit xa, input bit xb, input bit wr, input bit wide);
    bit busy, aw, dis, in_x, e_psen;
    int e_lo;
    busy   = xa || xb;
    aw     = (c % 6 < 2) && !(xb && c < 6);
    dis    = ale_dis && !(busy || code_rd || emu_mode || ext_exec);
    in_x   = (xa && c >= 6) || (xb && c < 6);
    e_psen = !(ext_exec && (c % 6 >= 3) && !(xa && c >= 6) && !(xb && c < 6));
    e_lo   = (aw && (ext_exec || (xa && c >= 6))) ? 1 :
             (((xa && c >= 8) || (xb && c < 6)) ? 2 : 0);
    if (dis) begin
      chk("R5 ale held", int'(ale), 1);
      chk("R5 ale_strong", int'(ale_strong), 0);
    end else if (xb && c < 2) begin
      chk("R2 ale skipped", int'(ale), 0);
      chk("R2 ale_strong", int'(ale_strong), 1);
    end else begin
      chk("R1 ale", int'(ale), int'(aw));
      chk("R1 ale_strong", int'(ale_strong), 1);
    end
    if (ext_exec) chk("R3 psen_n", int'(psen_n), int'(e_psen));
    else          chk("R4 psen_n", int'(psen_n), 1);
    chk("R6 rd_n", int'(rd_n), int'(!(xb && c < 6 && !wr)));
    chk("R6 wr_n", int'(wr_n), int'(!(xb && c < 6 && wr)));
    chk("R7 lo_mode", int'(lo_mode), e_lo);
    chk("R8 hi_addr_sel", int'(hi_addr_sel), in_x ? int'(wide) : int'(ext_exec));
    chk("R9 req_ready", int'(req_ready), int'(c == 11 && !busy));
  endtask

  task automatic align();
    while (!req_ready) @(negedge clk);
  endtask

  initial begin : watchdog
    int n;
    n = 0;
    while (!done && n < 150000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    int edges;
    // R11 reset state
    repeat (3) @(negedge clk);
    chk("R11 rd_n in reset", int'(rd_n), 1);
    chk("R11 wr_n in reset", int'(wr_n), 1);
    chk("R11 ready in reset", int'(req_ready), 0);
    chk("R11 ale at count 0", int'(ale), 1);
    rst_n = 1'b1;
    edges = 0;
    while (!req_ready) begin
      @(negedge clk);
      edges++;
    end
    chk("R11 first ready edge", edges, 11);

    // sweep of all mode and transfer combinations
    for (int cfg = 0; cfg < 64; cfg++) begin
      ext_exec  = cfg[0];
      ale_dis   = cfg[1];
      code_rd   = cfg[2];
      emu_mode  = cfg[3];
      req_wide  = cfg[4];
      req_write = cfg[5];
      align();
      req_valid = 1'b1;
      for (int i = 0; i < 36; i++) begin
        @(negedge clk);
        if (i == 0) req_valid = 1'b0;
        check_pos(i % 12, i < 12, (i >= 12) && (i < 24), cfg[5], cfg[4]);
      end
    end

    // R9: a request that never meets ready starts nothing
    ext_exec = 1; ale_dis = 0; code_rd = 0; emu_mode = 0; req_write = 0; req_wide = 1;
    align();
    repeat (6) @(negedge clk);
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check_pos(6, 0, 0, 0, 0);
    for (int i = 7; i < 24; i++) begin
      @(negedge clk);
      check_pos(i % 12, 0, 0, 0, 0);
    end

    // R10: idle then power-down overrides
    ale_dis = 1; ext_exec = 0;
    idle = 1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      chk("R10 idle ale", int'(ale), 1);
      chk("R10 idle psen_n", int'(psen_n), 1);
      chk("R10 idle ready", int'(req_ready), 0);
      chk("R10 idle lo_mode", int'(lo_mode), 0);
    end
    pdown = 1;
    for (int i = 0; i < 14; i++) begin
      @(negedge clk);
      chk("R10 pdown ale", int'(ale), 0);
      chk("R10 pdown psen_n", int'(psen_n), 0);
      chk("R10 pdown ready", int'(req_ready), 0);
      chk("R10 pdown strobes", int'({rd_n, wr_n}), 3);
    end
    idle = 0; pdown = 0; ale_dis = 0;
    repeat (2) @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule